// File: doc/BRIEF.md
# ADC Control and Status Register

This block is the software-facing control and status register of an analog-to-digital converter. One 8-bit register carries an end-of-conversion flag, an interrupt enable, a start bit, a single/scan mode select and a channel-select mask. Software programs the register through a simple read/write strobe port. A converter sequencer reports finished conversions back through per-channel done pulses and a scan-complete pulse. The block decides from these when a conversion job has ended, sets the end flag and drives an interrupt request.

In single mode one conversion on a selected channel ends the job, and the start bit then drops by itself. In scan mode the flag waits until every channel in the select mask has reported since the last scan-complete pulse, and the start bit stays set so that scanning continues. Software can clear the flag only in one way: it must first see the flag as 1 in a register read, and then write the flag bit as 0. A DMA-type master that services the interrupt can also clear the flag as a side effect of reading the conversion data. The sequencer and the converter are outside this block.

Top module: `adc_ctrl_status`

## Requirements
- R1: Synchronous reset, the standby input and the module-stop input each force the whole register to 0x00 at the next clock edge. They also force the read data to 0x00 and drive the interrupt low.
- R2: A read strobe loads the read data with the register value as it stood before that clock edge. The value is laid out as flag bit 7, interrupt enable bit 6, start bit 5, scan select bit 4, channel mask bits 3..0. The read data then holds until the next read.
- R3: A write strobe loads bits 6..0 from the write data at that clock edge. Writing 1 to bit 7 never sets the flag.
- R4: Writing bit 7 as 0 clears the flag only if a read before that write cycle returned the flag as 1. Otherwise the flag is unchanged.
- R5: A DMA data-read strobe clears the flag while the interrupt output is high. While the interrupt output is low, the strobe has no effect.
- R6: In single mode (bit 4 = 0) with start = 1, a done pulse on a channel inside the mask sets the flag and clears the start bit, unless a write happens in the same cycle. Done pulses on channels outside the mask are ignored.
- R7: In scan mode (bit 4 = 1) with start = 1, the flag sets on a scan-complete pulse only if every masked channel has pulsed done since the previous scan-complete pulse, counting the pulse's own cycle. Every scan-complete pulse restarts this tracking. The start bit is kept.
- R8: The interrupt output equals flag AND interrupt enable as registered values.
- R9: When a set event and a clear happen in the same cycle, the flag ends up set.
- R10: Clearing the flag drops the read-as-1 qualification. After a new set, a 0 write with no new read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby: forces the register to zero |
| mstop_i | input | 1 | Module stop: forces the register to zero |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ch_done_i | input | NCH | Per-channel conversion-done pulses |
| scan_done_i | input | 1 | Scan-complete pulse from the sequencer |
| dma_rd_i | input | 1 | DMA read strobe on the conversion data register |
| irq_o | output | 1 | End-of-conversion interrupt request |
| start_o | output | 1 | Start bit, to the sequencer |
| scan_o | output | 1 | Scan mode select, to the sequencer |
| chsel_o | output | NCH | Channel mask, to the sequencer |

## Verification
Some faults are visible one cycle later. A wrong armed bit shows up as a flag that survives, or wrongly clears on, a 0 write, and the next read or the interrupt line exposes it one cycle after that write. A stale scan-accumulation mask is also visible one cycle later. It shows as a flag that sets on a scan-complete pulse with channels missing, or that fails to set on a full scan, and the interrupt line and the next read expose it. A bench model mirrors every register-visible value each cycle, so any divergence is caught on the next read or interrupt sample.

// File: rtl/adc_cs_pkg.sv
package adc_cs_pkg;
  localparam int REG_W     = 8;
  localparam int SEL_W     = 4;
  localparam int BIT_FLAG  = 7;
  localparam int BIT_IE    = 6;
  localparam int BIT_START = 5;
  localparam int BIT_SCAN  = 4;
endpackage

// File: rtl/adc_cs_done_track.sv
module adc_cs_done_track #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           kill_i,
  input  logic           start_i,
  input  logic           scan_i,
  input  logic [NCH-1:0] sel_i,
  input  logic [NCH-1:0] ch_done_i,
  input  logic           scan_done_i,
  output logic           set_o,
  output logic           single_end_o
);
  logic [NCH-1:0] acc_q;
  logic [NCH-1:0] acc_all;
  logic           scan_end;

  always_comb begin
    acc_all      = acc_q | ch_done_i;
    single_end_o = start_i && !scan_i && (|(ch_done_i & sel_i));
    scan_end     = start_i && scan_i && scan_done_i && (|sel_i) &&
                   ((acc_all & sel_i) == sel_i);
    set_o        = single_end_o || scan_end;
  end

  always_ff @(posedge clk) begin
    if (kill_i || !(start_i && scan_i) || scan_done_i) acc_q <= '0;
    else                                              acc_q <= acc_all;
  end

  // R7: every scan-complete pulse restarts the channel tracking
  a_r7_acc_restart: assert property (@(posedge clk) disable iff (kill_i)
    scan_done_i |=> (acc_q == '0));
endmodule

// File: rtl/adc_cs_flag.sv
module adc_cs_flag (
  input  logic clk,
  input  logic kill_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_zero_i,
  input  logic dma_clr_i,
  output logic flag_o,
  output logic flag_next_o,
  output logic armed_o
);
  logic flag_q, armed_q, clr;

  always_comb begin
    clr         = (wr_zero_i && armed_q) || dma_clr_i;
    flag_next_o = set_i || (flag_q && !clr);
  end

  always_ff @(posedge clk) begin
    if (kill_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_next_o;
      armed_q <= flag_next_o && (armed_q || (rd_i && flag_q));
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  // R4: a falling flag needs an armed 0 write or a DMA clear
  a_r4_clear_cause: assert property (@(posedge clk) disable iff (kill_i)
    ($fell(flag_q) && !$past(kill_i)) |->
      ($past(dma_clr_i) || ($past(wr_zero_i) && $past(armed_q))));
  // R9: a set event always leaves the flag high
  a_r9_set_wins: assert property (@(posedge clk) disable iff (kill_i)
    set_i |=> flag_q);
  // R10: the armed bit never outlives the flag
  a_r10_arm_drop: assert property (@(posedge clk) disable iff (kill_i)
    armed_q |-> flag_q);
endmodule

// File: rtl/adc_ctrl_status.sv
module adc_ctrl_status #(
  parameter int NCH = adc_cs_pkg::SEL_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         standby_i,
  input  logic                         mstop_i,
  input  logic                         wr_en_i,
  input  logic                         rd_en_i,
  input  logic [adc_cs_pkg::REG_W-1:0] wdata_i,
  output logic [adc_cs_pkg::REG_W-1:0] rdata_o,
  input  logic [NCH-1:0]               ch_done_i,
  input  logic                         scan_done_i,
  input  logic                         dma_rd_i,
  output logic                         irq_o,
  output logic                         start_o,
  output logic                         scan_o,
  output logic [NCH-1:0]               chsel_o
);
  import adc_cs_pkg::*;

  logic             kill;
  logic             ie_q, start_q, scan_q;
  logic [NCH-1:0]   sel_q;
  logic [SEL_W-1:0] sel_pad;
  logic [REG_W-1:0] reg_val, rdata_q;
  logic             irq_q;
  logic             set_evt, single_end;
  logic             flag, flag_next, armed;
  logic             ie_n;

  assign kill = rst || standby_i || mstop_i;

  genvar gi;
  generate
    for (gi = 0; gi < SEL_W; gi++) begin : g_pad
      if (gi < NCH) begin : g_used
        assign sel_pad[gi] = sel_q[gi];
      end else begin : g_zero
        assign sel_pad[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    reg_val            = '0;
    reg_val[BIT_FLAG]  = flag;
    reg_val[BIT_IE]    = ie_q;
    reg_val[BIT_START] = start_q;
    reg_val[BIT_SCAN]  = scan_q;
    reg_val[SEL_W-1:0] = sel_pad;
    ie_n = wr_en_i ? wdata_i[BIT_IE] : ie_q;
  end

  adc_cs_done_track #(.NCH(NCH)) u_track (
    .clk(clk), .kill_i(kill), .start_i(start_q), .scan_i(scan_q),
    .sel_i(sel_q), .ch_done_i(ch_done_i), .scan_done_i(scan_done_i),
    .set_o(set_evt), .single_end_o(single_end)
  );

  adc_cs_flag u_flag (
    .clk(clk), .kill_i(kill), .set_i(set_evt), .rd_i(rd_en_i),
    .wr_zero_i(wr_en_i && !wdata_i[BIT_FLAG]),
    .dma_clr_i(dma_rd_i && irq_q),
    .flag_o(flag), .flag_next_o(flag_next), .armed_o(armed)
  );

  always_ff @(posedge clk) begin
    if (kill) begin
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      scan_q  <= 1'b0;
      sel_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en_i) begin
        ie_q    <= wdata_i[BIT_IE];
        start_q <= wdata_i[BIT_START];
        scan_q  <= wdata_i[BIT_SCAN];
        sel_q   <= wdata_i[NCH-1:0];
      end else if (single_end) begin
        start_q <= 1'b0;
      end
      if (rd_en_i) rdata_q <= reg_val;
      irq_q <= flag_next && ie_n;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
  assign start_o = start_q;
  assign scan_o  = scan_q;
  assign chsel_o = sel_q;

  // R1: any zeroing input leaves register, read data and interrupt at zero
  a_r1_zeroed: assert property (@(posedge clk)
    kill |=> (reg_val == '0 && rdata_q == '0 && !irq_q));
  // R8: interrupt tracks flag and enable
  a_r8_irq_match: assert property (@(posedge clk) disable iff (kill)
    irq_q == (flag && ie_q));
  // R6: single-mode end without a write drops start
  a_r6_start_drop: assert property (@(posedge clk) disable iff (kill)
    (single_end && !wr_en_i) |=> !start_q);
  // R7: in scan mode the flag rises only on a scan-complete pulse
  a_r7_scan_rise: assert property (@(posedge clk) disable iff (kill)
    ($rose(flag) && !$past(kill) && $past(scan_q)) |-> $past(scan_done_i));
  // R3: a write of bit 7 alone never raises the flag
  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (kill)
    ($rose(flag) && !$past(kill)) |-> $past(set_evt));
endmodule

// File: tb/adc_ctrl_status_bench.sv
module adc_ctrl_status_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, stby, mstop, wr, rd, scd, dma;
  logic [7:0] wd;
  logic [NCH-1:0] chd;
  logic [7:0] rdata;
  logic irq, start, scan;
  logic [NCH-1:0] chsel;

  adc_ctrl_status #(.NCH(NCH)) u_adc_ctrl_status (
    .clk(clk), .rst(rst), .standby_i(stby), .mstop_i(mstop),
    .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wd), .rdata_o(rdata),
    .ch_done_i(chd), .scan_done_i(scd), .dma_rd_i(dma),
    .irq_o(irq), .start_o(start), .scan_o(scan), .chsel_o(chsel)
  );

  int checks = 0, fails = 0;
  logic m_flag, m_ie, m_start, m_scan, m_armed, m_irq;
  logic [NCH-1:0] m_sel, m_acc;
  logic [7:0] m_rdata;

  function automatic logic [7:0] m_reg();
    return {m_flag, m_ie, m_start, m_scan, m_sel};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic hit_s, hit_c, set, clr, f_n;
    logic [NCH-1:0] acc_all;
    if (rst || stby || mstop) begin
      m_flag = 0; m_ie = 0; m_start = 0; m_scan = 0; m_sel = 0;
      m_armed = 0; m_acc = 0; m_rdata = 0; m_irq = 0;
    end else begin
      acc_all = m_acc | chd;
      hit_s = m_start && !m_scan && (|(chd & m_sel));
      hit_c = m_start && m_scan && scd && (|m_sel) && ((acc_all & m_sel) == m_sel);
      set = hit_s || hit_c;
      clr = (wr && !wd[7] && m_armed) || (dma && m_irq);
      if (rd) m_rdata = m_reg();
      f_n = set || (m_flag && !clr);
      m_armed = f_n && (m_armed || (rd && m_flag));
      m_acc = (m_start && m_scan && !scd) ? acc_all : '0;
      m_flag = f_n;
      if (wr) begin
        m_ie = wd[6]; m_start = wd[5]; m_scan = wd[4]; m_sel = wd[3:0];
      end else if (hit_s) m_start = 0;
      m_irq = m_flag && m_ie;
    end
  endtask

  task automatic cyc(input logic i_wr, input logic [7:0] i_wd, input logic i_rd,
                     input logic [NCH-1:0] i_chd, input logic i_scd, input logic i_dma);
    @(negedge clk);
    wr = i_wr; wd = i_wd; rd = i_rd; chd = i_chd; scd = i_scd; dma = i_dma;
    @(posedge clk);
    model_step();
    #1;
    chk(rdata, m_rdata, "R2");
    chk({7'd0, irq}, {7'd0, m_irq}, "R8");
    chk({start, scan, chsel}, {m_start, m_scan, m_sel}, "R3");
    @(negedge clk);
    rst = 0; stby = 0; mstop = 0;
    wr = 0; rd = 0; chd = 0; scd = 0; dma = 0;
  endtask

  task automatic wrt(input logic [7:0] v); cyc(1, v, 0, 0, 0, 0); endtask
  task automatic rdc();                    cyc(0, 0, 1, 0, 0, 0); endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1; stby = 0; mstop = 0; wr = 0; rd = 0; wd = 0; chd = 0; scd = 0; dma = 0;
    @(posedge clk); model_step(); #1;
    chk(rdata, 8'h00, "R1"); chk({7'd0, irq}, 8'h00, "R1");
    @(negedge clk); rst = 0;

    // single mode
    wrt(8'h61);
    chk({7'd0, start}, 8'h01, "R3");
    cyc(0, 0, 0, 4'b0010, 0, 0);
    chk({7'd0, irq}, 8'h00, "R6");
    cyc(0, 0, 0, 4'b0001, 0, 0);
    chk({7'd0, irq}, 8'h01, "R6");
    chk({7'd0, start}, 8'h00, "R6");
    // 0 write without prior read
    wrt(8'h41);
    rdc(); chk(rdata, 8'hC1, "R4");
    wrt(8'h41);
    rdc(); chk(rdata, 8'h41, "R4");
    chk({7'd0, irq}, 8'h00, "R8");
    // writing 1 to bit 7
    wrt(8'hE1);
    rdc(); chk(rdata, 8'h61, "R3");
    cyc(0, 0, 0, 4'b0001, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    rdc(); chk(rdata, 8'h41, "R5");
    wrt(8'h21);
    cyc(0, 0, 0, 4'b0001, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    rdc(); chk(rdata, 8'h81, "R5");
    // scan mode
    wrt(8'h33);
    cyc(0, 0, 0, 4'b0001, 0, 0);
    cyc(0, 0, 0, 4'b0010, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    rdc(); chk(rdata, 8'hB3, "R7");
    chk({7'd0, start}, 8'h01, "R7");
    cyc(1, 8'h33, 0, 4'b0011, 1, 0);
    rdc(); chk(rdata, 8'hB3, "R9");
    wrt(8'h33);
    rdc(); chk(rdata, 8'h33, "R4");
    cyc(0, 0, 0, 4'b0001, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    rdc(); chk(rdata, 8'h33, "R7");
    cyc(0, 0, 0, 4'b0011, 1, 0);
    wrt(8'h33);
    rdc(); chk(rdata, 8'hB3, "R10");
    // zeroing inputs
    @(negedge clk); stby = 1; cyc(0, 0, 0, 0, 0, 0);
    rdc(); chk(rdata, 8'h00, "R1");
    wrt(8'h7F);
    @(negedge clk); mstop = 1; cyc(0, 0, 0, 0, 0, 0);
    rdc(); chk(rdata, 8'h00, "R1");
    chk({start, scan, chsel}, 6'd0, "R1");

    // constrained random with sequencer stub
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      stby  = (r[5:0] == 6'd0);
      mstop = (r[11:6] == 6'd0);
      cyc((r[14:12] == 3'd0),
          {r[15], 1'b0, r[17:16] != 2'd0, r[18], r[22:19]} | {1'b0, r[23], 6'd0},
          r[24],
          (r[26:25] == 2'd0) ? 4'($urandom) : 4'd0,
          (r[29:27] == 3'd0),
          r[30] & r[31]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule